// File: doc/BRIEF.md
# PWM-Aligned Current/Voltage Sample Sequencer

This block decides when a rectified AC current sample and a rectified AC voltage sample are taken inside each PWM period. A one-cycle reference pulse marks the point in the PWM cycle from which timing is measured. The block then counts a programmable number of clock cycles before it asks the ADC for a current conversion. This delay compensates for the lag of the filtered current signal. As soon as the current result is captured, the block asks for a voltage conversion. After that it waits for the next reference pulse.

The current result register carries a completion flag in its least significant bit, with the converted value above it. A small calculation engine can read that register directly at any time. It can also execute a synchronising instruction that raises `sync_req`. The block holds `stall` high while that instruction waits for the flag, so the engine resumes only when fresh current data is present. The DC bus voltage path and the converter itself lie outside this block.

Top module: `pwm_sample_seq`

## Requirements
- R1: While reset is asserted and right after its release, `adc_req` is 0, `cur_reg` is 0 and `vlt_reg` is 0.
- R2: For a delay value D of 1 or more, the clock edge that samples `cyc_ref` high in the idle state is edge 0. `adc_req` rises after edge D, with `adc_chan` = 0 (channel code 0 selects current). Before that it stays low.
- R3: For a delay value of 0, `adc_req` is high with `adc_chan` = 0 right after the edge that samples the reference pulse.
- R4: Once raised, `adc_req` stays high and `adc_chan` stays unchanged until an edge samples `adc_ack` high.
- R5: An acknowledge on channel 0 loads `adc_data` into `cur_reg[ADC_W:1]` and sets `cur_reg[0]` to 1. On the next cycle `adc_req` remains high with `adc_chan` = 1 (channel code 1 selects voltage).
- R6: An acknowledge on channel 1 loads `adc_data` into `vlt_reg`, and `adc_req` is low on the next cycle.
- R7: A reference pulse accepted in the idle state clears `cur_reg[0]` and keeps the data field `cur_reg[ADC_W:1]` unchanged.
- R8: A reference pulse that arrives while a sequence is in progress is ignored. The sequence keeps its timing, `cur_reg[0]` is not cleared, and no new request follows once the sequence completes.
- R9: `stall` equals `sync_req` AND NOT `cur_reg[0]` at all times.
- R10: `adc_ack` while `adc_req` is low changes neither `cur_reg` nor `vlt_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_ref | input | 1 | One-cycle PWM cycle reference pulse |
| delay_cfg | input | DLY_W | Clock cycles from reference to current request |
| sync_req | input | 1 | High while the engine executes a synchronising instruction |
| adc_ack | input | 1 | One-cycle conversion done strobe from the ADC |
| adc_data | input | ADC_W | Conversion result, valid with `adc_ack` |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_chan | output | 1 | Channel select: 0 current, 1 voltage |
| cur_reg | output | ADC_W+1 | Current result in [ADC_W:1], completion flag in bit 0 |
| vlt_reg | output | ADC_W | Voltage result |
| stall | output | 1 | Halts the engine until fresh current data exist |

## Verification
The assertions assume that `adc_ack` is a single-cycle strobe, that it arrives only while a request is pending, and that `adc_data` is valid in the same cycle. They also assume that `cyc_ref` is a one-cycle pulse. The random stimulus follows these rules. The ADC model waits a random number of cycles and then strobes the acknowledge once. Stray acknowledges are applied only in the idle state, and the bench checks them separately. Extra reference pulses are injected on purpose during the waiting and conversion phases. This shows that they are dropped, while the delay value stays constant for each sequence.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CUR  = 2'd2,
    ST_VLT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sseq_rst_sync.sv
module sseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sseq_delay.sv
module sseq_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (en && (cnt_q != '0))
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = en && (cnt_q == ONE);
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_ref,
  input  logic       delay_zero,
  input  logic       expire,
  input  logic       adc_ack,
  output logic       cnt_load,
  output logic       cnt_en,
  output logic       cap_cur,
  output logic       cap_vlt,
  output logic       clr_done,
  output logic       adc_req,
  output logic       adc_chan
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cap_cur  = 1'b0;
    cap_vlt  = 1'b0;
    clr_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cyc_ref) begin
          clr_done = 1'b1;
          if (delay_zero) begin
            st_d = ST_CUR;
          end else begin
            cnt_load = 1'b1;
            st_d     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (expire) st_d = ST_CUR;
      end
      ST_CUR: begin
        if (adc_ack) begin
          cap_cur = 1'b1;
          st_d    = ST_VLT;
        end
      end
      ST_VLT: begin
        if (adc_ack) begin
          cap_vlt = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cnt_en   = (st_q == ST_WAIT);
  assign adc_req  = (st_q == ST_CUR) || (st_q == ST_VLT);
  assign adc_chan = (st_q == ST_VLT);
endmodule

// File: rtl/sseq_results.sv
module sseq_results #(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_cur,
  input  logic             cap_vlt,
  input  logic             clr_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic [ADC_W:0]   cur_reg,
  output logic [ADC_W-1:0] vlt_reg
);
  logic [ADC_W-1:0] cur_q, cur_d;
  logic [ADC_W-1:0] vlt_q, vlt_d;
  logic             done_q, done_d;

  always_comb begin
    cur_d  = cur_q;
    vlt_d  = vlt_q;
    done_d = done_q;
    if (cap_cur) begin
      cur_d  = adc_data;
      done_d = 1'b1;
    end else if (clr_done) begin
      done_d = 1'b0;
    end
    if (cap_vlt) vlt_d = adc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      vlt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cap_cur)            cur_q  <= cur_d;
      if (cap_vlt)            vlt_q  <= vlt_d;
      if (cap_cur || clr_done) done_q <= done_d;
    end
  end

  assign cur_reg = {cur_q, done_q};
  assign vlt_reg = vlt_q;
endmodule

// File: rtl/pwm_sample_seq.sv
module pwm_sample_seq #(
  parameter int DLY_W = 8,
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_ref,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             sync_req,
  input  logic             adc_ack,
  input  logic [ADC_W-1:0] adc_data,
  output logic             adc_req,
  output logic             adc_chan,
  output logic [ADC_W:0]   cur_reg,
  output logic [ADC_W-1:0] vlt_reg,
  output logic             stall
);
  logic rst_s_n;
  logic cnt_load, cnt_en, expire;
  logic cap_cur, cap_vlt, clr_done;
  logic delay_zero;

  assign delay_zero = (delay_cfg == '0);

  sseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sseq_delay #(.CNT_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (cnt_load),
    .load_val (delay_cfg),
    .en       (cnt_en),
    .expire   (expire)
  );

  sseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cyc_ref    (cyc_ref),
    .delay_zero (delay_zero),
    .expire     (expire),
    .adc_ack    (adc_ack),
    .cnt_load   (cnt_load),
    .cnt_en     (cnt_en),
    .cap_cur    (cap_cur),
    .cap_vlt    (cap_vlt),
    .clr_done   (clr_done),
    .adc_req    (adc_req),
    .adc_chan   (adc_chan)
  );

  sseq_results #(.ADC_W(ADC_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cap_cur  (cap_cur),
    .cap_vlt  (cap_vlt),
    .clr_done (clr_done),
    .adc_data (adc_data),
    .cur_reg  (cur_reg),
    .vlt_reg  (vlt_reg)
  );

  assign stall = sync_req & ~cur_reg[0];
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
  parameter int ADC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_req,
  input logic             adc_ack,
  input logic             adc_req,
  input logic             adc_chan,
  input logic [ADC_W:0]   cur_reg,
  input logic [ADC_W-1:0] vlt_reg,
  input logic             stall
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_ack |=> adc_req && $stable(adc_chan));

  assert_cur_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && adc_ack && !adc_chan |=> cur_reg[0] && adc_req && adc_chan);

  assert_vlt_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && adc_ack && adc_chan |=> !adc_req);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_req) |-> !adc_chan && !cur_reg[0]);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req && !cur_reg[0] |-> stall);

  assert_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_reg[0] |-> !stall);

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_req |=> $stable(cur_reg[ADC_W:1]) && $stable(vlt_reg));
endmodule

bind pwm_sample_seq sseq_chk #(.ADC_W(ADC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_req (sync_req),
  .adc_ack  (adc_ack),
  .adc_req  (adc_req),
  .adc_chan (adc_chan),
  .cur_reg  (cur_reg),
  .vlt_reg  (vlt_reg),
  .stall    (stall)
);

// File: tb/sim_pwm_sample_seq.sv
module sim_pwm_sample_seq;
  localparam int DLY_W = 8;
  localparam int ADC_W = 10;

  logic             clk;
  logic             rst_n;
  logic             cyc_ref;
  logic [DLY_W-1:0] delay_cfg;
  logic             sync_req;
  logic             adc_ack;
  logic [ADC_W-1:0] adc_data;
  logic             adc_req;
  logic             adc_chan;
  logic [ADC_W:0]   cur_reg;
  logic [ADC_W-1:0] vlt_reg;
  logic             stall;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int cyc = 0;

  pwm_sample_seq #(.DLY_W(DLY_W), .ADC_W(ADC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_ref(cyc_ref), .delay_cfg(delay_cfg),
    .sync_req(sync_req), .adc_ack(adc_ack), .adc_data(adc_data),
    .adc_req(adc_req), .adc_chan(adc_chan), .cur_reg(cur_reg),
    .vlt_reg(vlt_reg), .stall(stall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_stall(logic s, logic [ADC_W:0] c);
    return s & ~c[0];
  endfunction

  function automatic logic [ADC_W:0] exp_cur(logic [ADC_W-1:0] d, logic f);
    return {d, f};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  // One full sequence. extra: 1 = stray pulse while waiting, 2 = stray pulse in voltage phase.
  task automatic run_seq(int d, int li, int lv, logic [ADC_W-1:0] di,
                         logic [ADC_W-1:0] dv, int extra, logic sreq);
    logic [ADC_W-1:0] old_data;
    old_data = cur_reg[ADC_W:1];
    delay_cfg = DLY_W'(d);
    sync_req  = sreq;
    @(negedge clk);
    check("R8 idle before pulse", {31'd0, adc_req}, 32'd0);
    cyc_ref = 1'b1;
    @(negedge clk);
    cyc_ref = 1'b0;
    // first negedge after edge 0
    check("R7 flag cleared", {31'd0, cur_reg[0]}, 32'd0);
    check("R7 data kept", {22'd0, cur_reg[ADC_W:1]}, {22'd0, old_data});
    check("R9 stall while waiting", {31'd0, stall}, {31'd0, exp_stall(sreq, exp_cur(old_data, 1'b0))});
    for (int c = 1; c <= d; c++) begin
      if (extra == 1 && c == 1) cyc_ref = 1'b1;
      check(d == 0 ? "R3" : "R2 req low during delay", {31'd0, adc_req}, 32'd0);
      @(negedge clk);
      cyc_ref = 1'b0;
    end
    check(d == 0 ? "R3 req at once" : "R2 req after delay", {30'd0, adc_req, adc_chan}, 32'd2);
    for (int k = 0; k < li; k++) begin
      @(negedge clk);
      check("R4 req held current", {30'd0, adc_req, adc_chan}, 32'd2);
    end
    adc_ack = 1'b1;
    adc_data = di;
    @(negedge clk);
    adc_ack = 1'b0;
    adc_data = ~di;
    check("R5 current captured", {21'd0, cur_reg}, {21'd0, exp_cur(di, 1'b1)});
    check("R5 voltage requested", {30'd0, adc_req, adc_chan}, 32'd3);
    check("R9 stall released", {31'd0, stall}, 32'd0);
    for (int k = 0; k < lv; k++) begin
      if (extra == 2 && k == 0) cyc_ref = 1'b1;
      @(negedge clk);
      cyc_ref = 1'b0;
      check("R4 req held voltage", {30'd0, adc_req, adc_chan}, 32'd3);
      if (extra == 2) check("R8 flag not cleared", {31'd0, cur_reg[0]}, 32'd1);
    end
    adc_ack = 1'b1;
    adc_data = dv;
    @(negedge clk);
    adc_ack = 1'b0;
    check("R6 voltage captured", {22'd0, vlt_reg}, {22'd0, dv});
    check("R6 req dropped", {31'd0, adc_req}, 32'd0);
    if (extra != 0) begin
      for (int k = 0; k < d + 3; k++) begin
        @(negedge clk);
        check("R8 no restart", {31'd0, adc_req}, 32'd0);
      end
      check("R8 flag kept", {31'd0, cur_reg[0]}, 32'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cyc_ref = 1'b0; delay_cfg = '0; sync_req = 1'b0;
    adc_ack = 1'b0; adc_data = '0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", {31'd0, adc_req}, 32'd0);
    check("R1 cur in reset", {21'd0, cur_reg}, 32'd0);
    check("R1 vlt in reset", {22'd0, vlt_reg}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req after reset", {31'd0, adc_req}, 32'd0);
    check("R1 cur after reset", {21'd0, cur_reg}, 32'd0);
    sync_req = 1'b1;
    #1;
    check("R9 stall after reset", {31'd0, stall}, 32'd1);

    // directed corners
    run_seq(0, 0, 0, 10'h155, 10'h2AA, 0, 1'b1);
    run_seq(1, 2, 1, 10'h3FF, 10'h001, 0, 1'b0);
    run_seq(5, 1, 2, 10'h0F0, 10'h30F, 1, 1'b1);
    run_seq(3, 0, 3, 10'h123, 10'h321, 2, 1'b1);
    run_seq(0, 3, 0, 10'h000, 10'h3FF, 1, 1'b0);

    // stray acknowledges in idle
    @(negedge clk);
    begin
      logic [ADC_W:0]   c0;
      logic [ADC_W-1:0] v0;
      c0 = cur_reg; v0 = vlt_reg;
      adc_ack = 1'b1; adc_data = 10'h2D2;
      @(negedge clk);
      adc_ack = 1'b0;
      @(negedge clk);
      check("R10 cur unchanged", {21'd0, cur_reg}, {21'd0, c0});
      check("R10 vlt unchanged", {22'd0, vlt_reg}, {22'd0, v0});
      check("R10 no request", {31'd0, adc_req}, 32'd0);
    end

    for (int i = 0; i < 40; i++) begin
      run_seq(int'($urandom_range(0, 20)), int'($urandom_range(0, 6)),
              int'($urandom_range(0, 6)), ADC_W'($urandom), ADC_W'($urandom),
              int'($urandom_range(0, 2)), logic'($urandom_range(0, 1)));
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end

    summary();
  end
endmodule